// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running time-of-day and calendar value and raises an interrupt when it matches one of two alarm settings. Each alarm holds a target value for seconds, minutes, hours, day of month, month and weekday. Each of these six fields has its own enable bit. Only the enabled fields take part in the compare, so an alarm can fire once a minute, once a day, on one weekday, or at one exact instant.

The time counters are not part of this block. Their fields arrive as inputs, together with a one-cycle strobe that marks each new second. A compare is made only on that strobe, so one match gives exactly one event.

Each alarm works in one of two modes:
- **Single-shot (polled):** the alarm must be armed. It disarms itself when it fires.
- **Repeat (periodic):** the alarm fires on every strobe at which its enabled fields match.

A firing sets a sticky status flag for that alarm. Software clears the flag with a pulse. The active-low interrupt output, which stands in for an open-drain pin, is asserted while any flag is set.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset both status flags are 0, `irq_n` is 1 and both alarms are disarmed.
- R2: When `sec_tick` is high at a clock edge and the alarm is allowed to fire, the alarm fires if every enabled field equals the matching `now_*` input. The alarm's flag reads 1 after that edge. Target layout in `alm_target` for alarm k is at [k*34 +: 34], ordered from bit 0 as sec(7), min(7), hour(6), date(6), month(5), wday(3). Enable layout in `alm_en` for alarm k is at [k*6 +: 6], ordered from bit 0 as sec, min, hour, date, month, wday.
- R3: A field whose enable bit is 0 has no effect on the match, whatever its target value.
- R4: If any enabled field differs from the running time, the alarm does not fire on that strobe.
- R5: An alarm with all six enable bits at 0 never fires.
- R6: In single-shot mode (`alm_repeat[k]`=0), an alarm fires only while armed. Firing disarms it. A pulse on `alm_arm[k]` re-arms it. If firing and arming happen in the same cycle, firing wins.
- R7: In repeat mode (`alm_repeat[k]`=1), the alarm fires on every matching strobe, whether or not it is armed.
- R8: A status flag stays at 1 until a pulse on `alm_clr[k]` clears it. If the alarm fires in the same cycle as the clear, the flag stays 1.
- R9: `irq_n` is 0 exactly when at least one status flag is 1.
- R10: The two alarms are independent. The settings, arming and clearing of one alarm never change the flag of the other.
- R11: Without `sec_tick`, no alarm fires, even if its fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe for each new second; enables the compare |
| now_sec | input | 7 | Running seconds |
| now_min | input | 7 | Running minutes |
| now_hour | input | 6 | Running hours |
| now_date | input | 6 | Running day of month |
| now_month | input | 5 | Running month |
| now_wday | input | 3 | Running weekday |
| alm_target | input | 68 | Target fields of both alarms (layout in R2) |
| alm_en | input | 12 | Field enables of both alarms (layout in R2) |
| alm_repeat | input | 2 | Per-alarm repeat mode select |
| alm_arm | input | 2 | Per-alarm arm pulse |
| alm_clr | input | 2 | Per-alarm flag clear pulse |
| alm_flag | output | 2 | Per-alarm sticky status flag |
| irq_n | output | 1 | Active-low interrupt, low while any flag is set |

## Verification
The assertions assume the following about the inputs:
- `sec_tick` is a single-cycle pulse.
- The target, enable and mode inputs are quasi-static around a strobe. The properties tie the next-cycle flag to same-cycle enables, so they need those values to describe the compare that was actually made.

The stimulus keeps within these assumptions. It changes settings only on falling edges and only between strobes. It raises every strobe, arm pulse and clear pulse for exactly one cycle, and it holds all the other inputs steady across that cycle.

// File: rtl/cal_alarm_pkg.sv
// Package: shared widths and field layout for the calendar alarm comparator.
// Assumes six fields in a fixed order; the offsets are derived, not listed.
package cal_alarm_pkg;
    localparam int NUM_FIELDS = 6;

    // Width of field i (order: sec, min, hour, date, month, wday)
    function automatic int fld_w(input int i);
        case (i)
            0: return 7;
            1: return 7;
            2: return 6;
            3: return 6;
            4: return 5;
            default: return 3;
        endcase
    endfunction

    // Lowest bit of field i inside a packed time word
    function automatic int fld_lo(input int i);
        int s;
        s = 0;
        for (int j = 0; j < i; j++) s += fld_w(j);
        return s;
    endfunction

    localparam int TIME_W = fld_lo(NUM_FIELDS);
endpackage

// File: rtl/cal_field_cmp.sv
// Module: masked compare of one alarm target against the running time.
// Assumes both words use the package field layout. The result is
// combinational; an alarm with no enabled field never reports a hit.
module cal_field_cmp
    import cal_alarm_pkg::*;
(
    input  logic [TIME_W-1:0]     now_vec,
    input  logic [TIME_W-1:0]     tgt_vec,
    input  logic [NUM_FIELDS-1:0] fld_en,
    output logic                  hit
);
    logic [NUM_FIELDS-1:0] fld_ok;

    // One comparator per field; a disabled field always agrees
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam int LO = fld_lo(g);
        localparam int W  = fld_w(g);
        assign fld_ok[g] = !fld_en[g] || (now_vec[LO +: W] == tgt_vec[LO +: W]);
    end

    // All fields agree and at least one of them is enabled
    assign hit = (&fld_ok) && (|fld_en);
endmodule

// File: rtl/cal_alarm_slot.sv
// Module: state of one alarm: arm bit and sticky status flag.
// Assumes tick is a one-cycle strobe and hit comes from the field compare.
module cal_alarm_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic en_none,
    input  logic repeat_mode,
    input  logic arm,
    input  logic clr,
    output logic flag
);
    logic armed;
    logic fire;

    // Fire on a strobe when matched and allowed by the mode
    assign fire = tick && hit && (repeat_mode || armed);

    // Arm bit: a single-shot fire consumes it, an arm pulse restores it
    always_ff @(posedge clk) begin
        if (!rst_n)                     armed <= 1'b0;
        else if (fire && !repeat_mode)  armed <= 1'b0;
        else if (arm)                   armed <= 1'b1;
    end

    // Sticky flag: setting by a fire beats clearing
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (fire)   flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // R2
    set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && (repeat_mode || armed)) |=> flag);
    // R11
    no_set_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flag) |=> !flag);
    // R5
    no_fields_never_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_none && !flag) |=> !flag);
    // R6
    single_shot_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !repeat_mode) |=> !armed);
    // R8
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !tick) |=> !flag);
endmodule

// File: rtl/cal_alarm_match.sv
// Module: top of the calendar alarm comparator. Packs the running time,
// builds one compare and one state slot per alarm, and drives the
// active-low interrupt. Assumes the time inputs are stable around sec_tick.
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int N_ALM = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sec_tick,
    input  logic [6:0]                   now_sec,
    input  logic [6:0]                   now_min,
    input  logic [5:0]                   now_hour,
    input  logic [5:0]                   now_date,
    input  logic [4:0]                   now_month,
    input  logic [2:0]                   now_wday,
    input  logic [N_ALM*TIME_W-1:0]      alm_target,
    input  logic [N_ALM*NUM_FIELDS-1:0]  alm_en,
    input  logic [N_ALM-1:0]             alm_repeat,
    input  logic [N_ALM-1:0]             alm_arm,
    input  logic [N_ALM-1:0]             alm_clr,
    output logic [N_ALM-1:0]             alm_flag,
    output logic                         irq_n
);
    logic [TIME_W-1:0] now_vec;

    // Pack the running time in package field order
    assign now_vec = {now_wday, now_month, now_date, now_hour, now_min, now_sec};

    // One compare and one state slot per alarm
    for (genvar k = 0; k < N_ALM; k++) begin : g_alm
        logic hit;
        logic [NUM_FIELDS-1:0] en_k;
        assign en_k = alm_en[k*NUM_FIELDS +: NUM_FIELDS];

        cal_field_cmp u_cmp (
            .now_vec (now_vec),
            .tgt_vec (alm_target[k*TIME_W +: TIME_W]),
            .fld_en  (en_k),
            .hit     (hit)
        );

        cal_alarm_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (sec_tick),
            .hit         (hit),
            .en_none     (en_k == '0),
            .repeat_mode (alm_repeat[k]),
            .arm         (alm_arm[k]),
            .clr         (alm_clr[k]),
            .flag        (alm_flag[k])
        );
    end

    // Interrupt pin model: pulled low while any flag is pending
    assign irq_n = ~(|alm_flag);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (alm_flag == '0));
endmodule

// File: tb/sim_cal_alarm_match.sv
module sim_cal_alarm_match;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [6:0]  now_sec = '0;
    logic [6:0]  now_min = '0;
    logic [5:0]  now_hour = '0;
    logic [5:0]  now_date = '0;
    logic [4:0]  now_month = '0;
    logic [2:0]  now_wday = '0;
    logic [67:0] alm_target = '0;
    logic [11:0] alm_en = '0;
    logic [1:0]  alm_repeat = '0;
    logic [1:0]  alm_arm = '0;
    logic [1:0]  alm_clr = '0;
    logic [1:0]  alm_flag;
    logic        irq_n;
    int n_chk = 0;
    int n_bad = 0;

    cal_alarm_match u0 (.*);

    always #4 clk = ~clk;

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Set the running time
    task automatic set_now(input int s, input int m, input int h, input int d, input int mo, input int w);
        @(negedge clk);
        now_sec = 7'(s); now_min = 7'(m); now_hour = 6'(h);
        now_date = 6'(d); now_month = 5'(mo); now_wday = 3'(w);
    endtask

    // Program alarm k: target fields, enables, repeat mode
    task automatic set_alm(input int k, input int s, input int m, input int h, input int d,
                           input int mo, input int w, input logic [5:0] en, input logic rep);
        @(negedge clk);
        alm_target[k*34 +: 34] = {3'(w), 5'(mo), 6'(d), 6'(h), 7'(m), 7'(s)};
        alm_en[k*6 +: 6] = en;
        alm_repeat[k] = rep;
    endtask

    task automatic tick1();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic arm1(input int k);
        @(negedge clk); alm_arm[k] = 1'b1;
        @(negedge clk); alm_arm[k] = 1'b0;
    endtask

    task automatic clr1(input int k);
        @(negedge clk); alm_clr[k] = 1'b1;
        @(negedge clk); alm_clr[k] = 1'b0;
    endtask

    function automatic logic [2:0] obs();
        return {irq_n, alm_flag};
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", obs(), 3'b100);
        tick1();
        chk("R1 disarmed after reset", obs(), 3'b100);
    endtask

    task automatic t_single();
        set_now(30, 15, 8, 12, 6, 3);
        set_alm(0, 30, 15, 8, 12, 6, 3, 6'b111111, 1'b0);
        arm1(0);
        tick1();
        chk("R2 full match fires", obs(), 3'b001);
        chk("R9 irq low with flag", {2'b00, irq_n}, 3'b000);
        clr1(0);
        chk("R8 clear pulse", obs(), 3'b100);
        tick1();
        chk("R6 disarmed after fire", obs(), 3'b100);
        arm1(0);
        tick1();
        chk("R6 re-armed fires", obs(), 3'b001);
        clr1(0);
    endtask

    task automatic t_mask();
        set_alm(0, 30, 15, 22, 1, 1, 0, 6'b000011, 1'b0);
        arm1(0);
        tick1();
        chk("R3 disabled fields ignored", obs(), 3'b001);
        clr1(0);
        set_alm(0, 30, 15, 22, 12, 6, 3, 6'b000101, 1'b0);
        arm1(0);
        tick1();
        chk("R4 enabled mismatch blocks", obs(), 3'b100);
        set_alm(0, 0, 0, 0, 0, 0, 0, 6'b000000, 1'b0);
    endtask

    task automatic t_noen();
        set_alm(1, 30, 15, 8, 12, 6, 3, 6'b000000, 1'b1);
        tick1();
        tick1();
        chk("R5 no fields never fires", obs(), 3'b100);
    endtask

    task automatic t_notick();
        set_alm(1, 30, 15, 8, 12, 6, 3, 6'b111111, 1'b1);
        repeat (6) @(negedge clk);
        chk("R11 match without tick", obs(), 3'b100);
    endtask

    task automatic t_repeat();
        set_alm(1, 45, 0, 0, 0, 0, 0, 6'b000001, 1'b1);
        set_now(45, 1, 2, 3, 4, 5);
        tick1();
        chk("R7 repeat first fire", obs(), 3'b010);
        chk("R10 other alarm untouched", {2'b00, alm_flag[0]}, 3'b000);
        clr1(1);
        set_now(45, 2, 2, 3, 4, 5);
        tick1();
        chk("R7 repeat fires again unarmed", obs(), 3'b010);
        clr1(0);
        chk("R10 clearing other keeps flag", obs(), 3'b010);
        set_now(46, 2, 2, 3, 4, 5);
        tick1();
        tick1();
        chk("R8 flag sticky over ticks", obs(), 3'b010);
        set_now(45, 3, 2, 3, 4, 5);
        @(negedge clk); alm_clr[1] = 1'b1; sec_tick = 1'b1;
        @(negedge clk); alm_clr[1] = 1'b0; sec_tick = 1'b0;
        chk("R8 fire beats clear", obs(), 3'b010);
        clr1(1);
        chk("R9 irq released", obs(), 3'b100);
    endtask

    initial begin
        t_reset();
        t_single();
        t_mask();
        t_noen();
        t_notick();
        t_repeat();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule